// File: doc/BRIEF.md
# Masked Packed Half-Precision Adder

This block adds two packed vectors of IEEE binary16 numbers lane by lane and writes each sum into a destination vector under a per-lane write mask. The active length is 128, 256 or 512 bits, so 8, 16 or 32 lanes take part. A lane the mask leaves out is either cleared or keeps its old destination value. Destination bits above the active length are always cleared. The second operand can be a memory operand that carries a single scalar, which is then added to every lane. The rounding mode comes from the global control, except in the one case where an embedded rounding field overrides it.

Every lane is a complete binary16 adder. It handles subnormals, infinities and NaNs and rounds in all four directed modes. The lanes that write together raise five exception conditions. The result and the flags are registered once, so each accepted operation appears one clock after it is presented.

Top module: `hpadd_vec`

## Requirements
- R1: `vlen_sel` sets the number of active lanes: 00 gives 8, 01 gives 16, 10 gives 32. The code 11 acts exactly like 10. Lane j occupies bits [16j+15:16j] of every vector port.
- R2: An active lane whose mask bit is 1, or any active lane when `mask_en` is 0, receives the correctly rounded binary16 sum of its two operands. An exact zero sum of operands with unlike signs is +0, or -0 under round-down. Two zeros of the same sign keep that sign.
- R3: An active lane whose mask bit is 0, while `mask_en` and `zero_mode` are both 1, is written as 16'h0000.
- R4: An active lane whose mask bit is 0, while `mask_en` is 1 and `zero_mode` is 0, takes the matching lane of `old_dst`.
- R5: Every bit of `dst` above 16 times the active lane count is 0 after each operation.
- R6: When `b_is_mem` and `bcast` are both 1, bits [15:0] of `src_b` are the second operand of every lane. When `b_is_mem` is 0, `bcast` never replicates anything.
- R7: The rounding mode is `embed_rc` when `b_is_mem` is 0, `bcast` is 1 and `vlen_sel[1]` is 1. In every other case it is `global_rc`.
- R8: Rounding codes are 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero. A rounded magnitude beyond 65504 becomes infinity under nearest-even. It also becomes infinity when the mode rounds away from zero for that sign. Otherwise it becomes 65504 with the sum's sign.
- R9: If either input is a NaN, the result is the first NaN operand (src_a before src_b) with its quiet bit 9 set. Infinities of opposite sign give 16'h7E00. Otherwise an infinite operand gives that infinity.
- R10: `flags` bit 0 is invalid (signaling NaN input, or infinity minus infinity). Bit 1 is denormal (a subnormal operand). Bit 2 is overflow. Bit 3 is underflow (a sum below 2^-14 before rounding that is also inexact). Bit 4 is precision (rounded differs from exact, including overflow).
- R11: `flags` is the OR over lanes that are both active and written. A lane that is masked off or inactive contributes nothing.
- R12: `out_valid` follows `in_valid` one clock later, and `dst` and `flags` update only for a valid input. A synchronous `rst` clears `dst`, `flags` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| vlen_sel | input | 2 | Active length code (R1) |
| src_a | input | 512 | First packed operand |
| src_b | input | 512 | Second packed operand, register or memory |
| b_is_mem | input | 1 | Second operand is a memory operand |
| bcast | input | 1 | Broadcast / rounding-override flag |
| mask_en | input | 1 | Write mask in use |
| mask | input | 32 | Per-lane write mask |
| zero_mode | input | 1 | Clear masked lanes instead of merging |
| embed_rc | input | 2 | Embedded rounding control |
| global_rc | input | 2 | Global rounding control |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | `dst` and `flags` hold a new result |
| dst | output | 512 | Packed result |
| flags | output | 5 | Exception conditions of the last operation |

## Verification
The hardest situation to reach from the ports is a case where every special class meets every other class under every rounding mode. That means subnormal against near-overflow, signaling NaN against infinity, and exact cancellation under round-down. Random data almost never lines these up. The bench builds a set of 32 chosen binary16 values and packs all 1024 ordered pairs into full-length vectors, 32 pairs per operation, once for each rounding mode. It then adds random vectors that mix special values with random bit patterns, together with random masks, lengths and operand modes. Every expected sum comes from real-number arithmetic followed by explicit quantization in the bench.

// File: rtl/hpadd_pkg.sv
package hpadd_pkg;
  localparam int HW = 16;
  localparam int AW = 41;
  localparam int FL_INV = 0;
  localparam int FL_DEN = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_PRE = 4;
  localparam logic [1:0] RC_NE = 2'b00;
  localparam logic [1:0] RC_DN = 2'b01;
  localparam logic [1:0] RC_UP = 2'b10;
  localparam logic [1:0] RC_TZ = 2'b11;

  typedef struct packed {
    logic [4:0]  flg;
    logic [15:0] val;
  } hp_res_t;

  // operand magnitude on an absolute grid of 2^-24 units
  function automatic logic [AW-1:0] hp_grid(input logic [15:0] h);
    logic [4:0] ex;
    ex = (h[14:10] == 5'd0) ? 5'd1 : h[14:10];
    return AW'({h[14:10] != 5'd0, h[9:0]}) << (ex - 5'd1);
  endfunction

  function automatic hp_res_t hp_add(input logic [15:0] a, input logic [15:0] b,
                                     input logic [1:0] rc);
    hp_res_t r;
    logic a_nan, b_nan, a_inf, b_inf, s, g, st, inc, to_inf;
    logic [AW-1:0] ma, mb, m, kept;
    logic [16:0] enc, rnd;
    int p, lsb;
    r = '0;
    a_nan = (a[14:10] == 5'h1f) && (a[9:0] != 10'd0);
    b_nan = (b[14:10] == 5'h1f) && (b[9:0] != 10'd0);
    a_inf = (a[14:10] == 5'h1f) && (a[9:0] == 10'd0);
    b_inf = (b[14:10] == 5'h1f) && (b[9:0] == 10'd0);
    r.flg[FL_DEN] = ((a[14:10] == 5'd0) && (a[9:0] != 10'd0)) ||
                    ((b[14:10] == 5'd0) && (b[9:0] != 10'd0));
    if (a_nan || b_nan) begin
      r.val = a_nan ? (a | 16'h0200) : (b | 16'h0200);
      r.flg[FL_INV] = (a_nan && !a[9]) || (b_nan && !b[9]);
    end else if (a_inf && b_inf && (a[15] != b[15])) begin
      r.val = 16'h7e00;
      r.flg[FL_INV] = 1'b1;
    end else if (a_inf) begin
      r.val = a;
    end else if (b_inf) begin
      r.val = b;
    end else begin
      ma = hp_grid(a);
      mb = hp_grid(b);
      if (a[15] == b[15]) begin
        m = ma + mb;
        s = a[15];
      end else if (ma >= mb) begin
        m = ma - mb;
        s = a[15];
      end else begin
        m = mb - ma;
        s = b[15];
      end
      if (m == '0) begin
        r.val = {(a[15] == b[15]) ? a[15] : (rc == RC_DN), 15'd0};
      end else begin
        p = 0;
        for (int i = 0; i < AW; i++) if (m[i]) p = i;
        lsb = (p > 10) ? p - 10 : 0;
        kept = m >> lsb;
        g = 1'b0;
        st = 1'b0;
        for (int i = 0; i < AW; i++) begin
          if (i == lsb - 1) g = g | m[i];
          else if (i < lsb - 1) st = st | m[i];
        end
        enc = (p >= 10) ? (17'((lsb + 1) << 10) + 17'(kept[9:0])) : 17'(kept[9:0]);
        case (rc)
          RC_NE:   inc = g & (st | kept[0]);
          RC_DN:   inc = s & (g | st);
          RC_UP:   inc = !s & (g | st);
          default: inc = 1'b0;
        endcase
        rnd = enc + 17'(inc);
        r.flg[FL_PRE] = g | st;
        r.flg[FL_UNF] = (p < 10) && (g | st);
        if (rnd >= 17'h07c00) begin
          to_inf = (rc == RC_NE) || ((rc == RC_DN) && s) || ((rc == RC_UP) && !s);
          r.val = {s, to_inf ? 15'h7c00 : 15'h7bff};
          r.flg[FL_OVF] = 1'b1;
          r.flg[FL_PRE] = 1'b1;
        end else begin
          r.val = {s, rnd[14:0]};
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/hpadd_rmode.sv
module hpadd_rmode (
  input  logic       b_is_mem,
  input  logic       bcast,
  input  logic       full_len,
  input  logic [1:0] embed_rc,
  input  logic [1:0] global_rc,
  output logic [1:0] rc_sel
);
  logic use_embed;
  assign use_embed = !b_is_mem && bcast && full_len;
  assign rc_sel    = use_embed ? embed_rc : global_rc;
endmodule

// File: rtl/hpadd_lane.sv
module hpadd_lane
  import hpadd_pkg::*;
(
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic [15:0] old,
  input  logic [1:0]  rc,
  input  logic        live,
  input  logic        wr,
  input  logic        zero_mode,
  output logic [15:0] nxt,
  output logic [4:0]  flg
);
  hp_res_t sum;
  assign sum = hp_add(a, b, rc);

  always_comb begin
    flg = '0;
    if (!live)          nxt = '0;
    else if (wr) begin
      nxt = sum.val;
      flg = sum.flg;
    end
    else if (zero_mode) nxt = '0;
    else                nxt = old;
  end
endmodule

// File: rtl/hpadd_vec.sv
module hpadd_vec #(
  parameter int MAX_LANES = 32,
  parameter int MIN_LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [1:0]              vlen_sel,
  input  logic [MAX_LANES*16-1:0] src_a,
  input  logic [MAX_LANES*16-1:0] src_b,
  input  logic                    b_is_mem,
  input  logic                    bcast,
  input  logic                    mask_en,
  input  logic [MAX_LANES-1:0]    mask,
  input  logic                    zero_mode,
  input  logic [1:0]              embed_rc,
  input  logic [1:0]              global_rc,
  input  logic [MAX_LANES*16-1:0] old_dst,
  output logic                    out_valid,
  output logic [MAX_LANES*16-1:0] dst,
  output logic [4:0]              flags
);
  localparam int VW = MAX_LANES * 16;

  logic [1:0]           rc_sel;
  logic                 full_len;
  logic                 b_spread;
  logic [MAX_LANES-1:0] lane_live;
  logic [MAX_LANES-1:0] lane_wr;
  logic [VW-1:0]        nxt_vec;
  logic [4:0]           lane_flg [MAX_LANES];
  logic [4:0]           flg_or;
  int                   live_cnt;

  assign full_len = vlen_sel[1];
  assign b_spread = b_is_mem && bcast;
  assign live_cnt = full_len ? MAX_LANES : (MIN_LANES << vlen_sel[0]);

  hpadd_rmode u_rm (
    .b_is_mem (b_is_mem),
    .bcast    (bcast),
    .full_len (full_len),
    .embed_rc (embed_rc),
    .global_rc(global_rc),
    .rc_sel   (rc_sel)
  );

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [15:0] b_op;
    assign lane_live[j] = (j < live_cnt);
    assign lane_wr[j]   = !mask_en || mask[j];
    assign b_op         = b_spread ? src_b[15:0] : src_b[16*j +: 16];
    hpadd_lane u_ln (
      .a        (src_a[16*j +: 16]),
      .b        (b_op),
      .old      (old_dst[16*j +: 16]),
      .rc       (rc_sel),
      .live     (lane_live[j]),
      .wr       (lane_wr[j]),
      .zero_mode(zero_mode),
      .nxt      (nxt_vec[16*j +: 16]),
      .flg      (lane_flg[j])
    );
  end

  always_comb begin
    flg_or = '0;
    for (int j = 0; j < MAX_LANES; j++) flg_or = flg_or | lane_flg[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst       <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst   <= nxt_vec;
        flags <= flg_or;
      end
    end
  end
endmodule

// File: rtl/hpadd_vec_chk.sv
module hpadd_vec_chk #(
  parameter int MAX_LANES = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [1:0]              vlen_sel,
  input logic                    mask_en,
  input logic [MAX_LANES-1:0]    mask,
  input logic                    zero_mode,
  input logic [MAX_LANES*16-1:0] old_dst,
  input logic                    out_valid,
  input logic [MAX_LANES*16-1:0] dst,
  input logic [4:0]              flags
);
  localparam int VW = MAX_LANES * 16;

  p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dst) && $stable(flags) && !out_valid);

  p_upper_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'b00) |=> (dst[VW-1:128] == '0));

  p_zero_lane0_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mode && !mask[0]) |=> (dst[15:0] == 16'h0000));

  p_merge_lane0_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !zero_mode && !mask[0]) |=> (dst[15:0] == $past(old_dst[15:0])));

  p_quiet_flags_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && mask == '0) |=> (flags == 5'd0));
endmodule

bind hpadd_vec hpadd_vec_chk #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .vlen_sel (vlen_sel),
  .mask_en  (mask_en),
  .mask     (mask),
  .zero_mode(zero_mode),
  .old_dst  (old_dst),
  .out_valid(out_valid),
  .dst      (dst),
  .flags    (flags)
);

// File: tb/sim_hpadd_vec.sv
module sim_hpadd_vec;
  localparam int NL = 32;
  localparam int VW = NL * 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    vl = '0;
  logic [VW-1:0] sa = '0, sb = '0, od = '0;
  logic          bm = 1'b0, bc = 1'b0, me = 1'b0, zm = 1'b0;
  logic [NL-1:0] mk = '0;
  logic [1:0]    erc = '0, grc = '0;
  logic          out_valid;
  logic [VW-1:0] dst;
  logic [4:0]    flags;

  logic [VW-1:0] exp_d;
  logic [4:0]    exp_f;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hpadd_vec u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vlen_sel(vl),
    .src_a(sa), .src_b(sb), .b_is_mem(bm), .bcast(bc),
    .mask_en(me), .mask(mk), .zero_mode(zm), .embed_rc(erc),
    .global_rc(grc), .old_dst(od), .out_valid(out_valid), .dst(dst), .flags(flags)
  );

  function automatic real p2(input int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic real h2r(input logic [15:0] h);
    real mag;
    if (h[14:10] == 5'd0) mag = real'(h[9:0]) * p2(-24);
    else mag = (1024.0 + real'(h[9:0])) * p2(int'(h[14:10]) - 25);
    return h[15] ? -mag : mag;
  endfunction

  // reference sum: {flags, value}
  function automatic logic [20:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic [1:0] rc);
    logic [4:0] f = '0;
    logic [15:0] v;
    bit an, bn, ai, bi, neg, up;
    real s, mag, q, n, fl, fr, r;
    int e;
    an = (a[14:10] == 31) && (a[9:0] != 0);
    bn = (b[14:10] == 31) && (b[9:0] != 0);
    ai = (a[14:10] == 31) && (a[9:0] == 0);
    bi = (b[14:10] == 31) && (b[9:0] == 0);
    f[1] = ((a[14:10] == 0) && (a[9:0] != 0)) || ((b[14:10] == 0) && (b[9:0] != 0));
    if (an || bn) begin
      v = an ? {a[15:10], 1'b1, a[8:0]} : {b[15:10], 1'b1, b[8:0]};
      f[0] = (an && !a[9]) || (bn && !b[9]);
    end else if (ai && bi && a[15] != b[15]) begin
      v = 16'h7e00; f[0] = 1'b1;
    end else if (ai) v = a;
    else if (bi) v = b;
    else begin
      s = h2r(a) + h2r(b);
      if (s == 0.0) begin
        v = 16'h0000;
        v[15] = (a[15] == b[15]) ? a[15] : (rc == 2'b01);
      end else begin
        neg = (s < 0.0);
        mag = neg ? -s : s;
        if (mag < p2(-14)) q = p2(-24);
        else begin
          e = -14;
          while (mag >= p2(e + 1)) e++;
          q = p2(e - 10);
        end
        n = mag / q;
        fl = $floor(n);
        fr = n - fl;
        case (rc)
          2'b00: up = (fr > 0.5) || (fr == 0.5 && ($rtoi(fl) % 2 == 1));
          2'b01: up = neg && fr > 0.0;
          2'b10: up = !neg && fr > 0.0;
          default: up = 1'b0;
        endcase
        r = (fl + (up ? 1.0 : 0.0)) * q;
        f[4] = (fr > 0.0);
        f[3] = (fr > 0.0) && (mag < p2(-14));
        if (r >= 65536.0) begin
          f[2] = 1'b1; f[4] = 1'b1;
          if (rc == 2'b00 || (rc == 2'b01 && neg) || (rc == 2'b10 && !neg)) v = 16'h7c00;
          else v = 16'h7bff;
          v[15] = neg;
        end else begin
          if (r < p2(-14)) v = 16'($rtoi(r / p2(-24)));
          else begin
            e = -14;
            while (r >= p2(e + 1)) e++;
            v = 16'(((e + 15) << 10) + ($rtoi(r / p2(e - 10)) - 1024));
          end
          v[15] = neg;
        end
      end
    end
    return {f, v};
  endfunction

  task automatic model;
    int nact;
    logic [1:0] rc;
    logic [15:0] bj;
    logic [20:0] rr;
    nact = vl[1] ? 32 : (vl[0] ? 16 : 8);
    rc = (!bm && bc && vl[1]) ? erc : grc;
    exp_d = '0;
    exp_f = '0;
    for (int j = 0; j < NL; j++) begin
      if (j < nact) begin
        bj = (bm && bc) ? sb[15:0] : sb[16*j +: 16];
        if (!me || mk[j]) begin
          rr = ref_add(sa[16*j +: 16], bj, rc);
          exp_d[16*j +: 16] = rr[15:0];
          exp_f = exp_f | rr[20:16];
        end else if (!zm) exp_d[16*j +: 16] = od[16*j +: 16];
      end
    end
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (dst !== exp_d || flags !== exp_f || out_valid !== 1'b1) begin
      n_err++;
      for (int j = 0; j < NL; j++)
        if (dst[16*j +: 16] !== exp_d[16*j +: 16]) begin
          $display("FAIL %s lane %0d a=%h b=%h got %h expected %h", tag, j,
                   sa[16*j +: 16], sb[16*j +: 16], dst[16*j +: 16], exp_d[16*j +: 16]);
          break;
        end
      if (flags !== exp_f || out_valid !== 1'b1)
        $display("FAIL %s flags/valid got %b/%b expected %b/1", tag, flags, out_valid, exp_f);
    end
  endtask

  // called at a negedge; result checked one clock later
  task automatic do_op(input string tag);
    in_valid = 1'b1;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [15:0] pick(input int k);
    logic [14:0] m;
    case (k % 16)
      0: m = 15'h0000;  1: m = 15'h0001;  2: m = 15'h03ff;  3: m = 15'h0400;
      4: m = 15'h3c00;  5: m = 15'h3c01;  6: m = 15'h7bff;  7: m = 15'h7c00;
      8: m = 15'h7e00;  9: m = 15'h7d00; 10: m = 15'h1400; 11: m = 15'h5000;
      12: m = 15'h0200; 13: m = 15'h3555; 14: m = 15'h6800; default: m = 15'h0800;
    endcase
    return {k[4], m};
  endfunction

  function automatic logic [VW-1:0] rvec;
    logic [VW-1:0] v;
    for (int j = 0; j < NL; j++)
      v[16*j +: 16] = ($urandom % 4 == 0) ? pick($urandom % 32) : 16'($urandom);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    n_chk++;
    if (dst !== '0 || flags !== 5'd0 || out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R12 reset got valid=%b flags=%b expected 0/0", out_valid, flags);
    end
    rst = 1'b0;

    // R2 R8 R9 R10: every ordered pair of 32 chosen values, all rounding modes
    for (int rc = 0; rc < 4; rc++) begin
      vl = 2'b10; bm = 0; bc = 0; me = 0; zm = 0; grc = 2'(rc); erc = 2'(3 - rc);
      for (int op = 0; op < 32; op++) begin
        for (int j = 0; j < NL; j++) begin
          sa[16*j +: 16] = pick(op);
          sb[16*j +: 16] = pick(j);
        end
        do_op("R2/R8/R9/R10 sweep");
      end
    end

    // R7: embedded rounding with register operand at full length
    sa = {NL{16'h3c00}}; sb = {NL{16'h0001}};
    vl = 2'b10; bm = 0; bc = 1; me = 0; grc = 2'b00; erc = 2'b10;
    do_op("R7 embedded up");
    vl = 2'b01; do_op("R7 global at 256");
    vl = 2'b11; erc = 2'b11; grc = 2'b10; do_op("R7 code 11 embedded");
    bm = 1; vl = 2'b10; do_op("R7 memory keeps global");

    // R6: broadcast of element 0
    sa = rvec(); sb = rvec(); bm = 1; bc = 1; vl = 2'b10; grc = 2'b00;
    do_op("R6 memory broadcast");
    bm = 0; vl = 2'b01; do_op("R6 register no broadcast");

    // R1 R5: lengths
    bc = 0; bm = 0;
    for (int k = 0; k < 4; k++) begin
      sa = rvec(); sb = rvec(); vl = 2'(k);
      do_op(k == 0 ? "R5 upper clear 128" : "R1 lane count");
    end

    // R3 R4 R11: masking
    sa = rvec(); sb = rvec(); od = rvec(); vl = 2'b10; me = 1;
    mk = 32'h5a5a_a5a5; zm = 1; do_op("R3 zeroing");
    zm = 0; do_op("R4 merging");
    sa = {NL{16'h7d00}}; sb = {NL{16'h7c00}}; mk = '0; do_op("R11 masked no flags");
    mk = 32'h0000_0100; vl = 2'b00; do_op("R11 inactive lane no flags");

    // R12: idle cycle holds
    @(negedge clk);
    in_valid = 1'b0;
    sa = rvec(); od = rvec();
    @(negedge clk);
    n_chk++;
    if (dst !== exp_d || flags !== exp_f || out_valid !== 1'b0) begin
      n_err++;
      $display("FAIL R12 idle got valid=%b expected 0, dst changed=%b", out_valid, dst !== exp_d);
    end

    // mixed random operations
    for (int i = 0; i < 1500; i++) begin
      sa = rvec(); sb = rvec(); od = rvec();
      vl = 2'($urandom); bm = 1'($urandom); bc = 1'($urandom);
      me = 1'($urandom); zm = 1'($urandom); mk = $urandom;
      erc = 2'($urandom); grc = 2'($urandom);
      do_op("R2 random mix");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule